// File: doc/BRIEF.md
# Gated Pulse-Width Measurement Counter

This block measures how long a gate input stays in its active level. While the gate is active it counts edges of a separate periodic source input. The product of the count and the source period is the pulse width; that conversion is done outside the block. The gate, source and sample-clock inputs are asynchronous to the system clock. Each is brought in through a two-flop synchronizer, and its edges are found by comparing the synchronized value with the value one clock earlier.

A one-cycle arm strobe starts a measurement. The strobe also clears the sticky error flags. Three modes exist. Single mode records one pulse and then stops. Implicit buffered mode records every pulse. Sample-clocked mode reports the most recently completed width on each rising edge of a sample clock. Results go into a small FIFO that is drained through a valid/ready read port. Three sticky flags report a sample clock with no new pulse, a saturated width counter, and a dropped FIFO write.

Top module: `pulse_width_meter`

## Requirements
- R1: After reset the read port shows no data (`rd_valid`=0), all three flags are 0, and the block is disarmed. Gate pulses before the first `arm` store nothing.
- R2: `cfg_gate_low`=0 measures high periods of `gate_in`. `cfg_gate_low`=1 measures low periods.
- R3: While a pulse is being measured, the count grows by one on each selected edge of `src_in`: rising edges when `cfg_src_fall`=0, falling edges when it is 1. Edges of the other direction do not count.
- R4: If `arm` arrives while the gate is already active, that partial pulse is skipped. Each entry into the active level clears the count before counting starts.
- R5: With `cfg_mode`=2'b00 (or 2'b11), the first completed pulse after `arm` is written to the FIFO. All later gate, source and sample-clock activity is ignored until the next `arm`.
- R6: With `cfg_mode`=2'b01, every trailing edge of the gate writes that pulse's count to the FIFO, and measuring continues with the next pulse.
- R7: With `cfg_mode`=2'b10, each rising edge of `smp_in` writes the width of the most recently completed pulse to the FIFO. A completed width is written only once.
- R8: In mode 2'b10, a sample edge with no pulse completed since the previous sample edge (or since `arm`) writes nothing and sets the sticky `overrun` flag.
- R9: The width count stops at 2^CNT_W-1. Any further selected edge leaves it there and sets the sticky `sat_flag`.
- R10: A write to a full FIFO (full before any pop in the same cycle) is dropped and sets the sticky `fifo_ovf`. `arm` or reset clears `fifo_ovf`, `overrun` and `sat_flag`.
- R11: The read port pops one entry on each cycle with `rd_valid` and `rd_ready` both high. Entries come out in write order. `rd_data` holds the count zero-extended to 32 bits and stays stable while `rd_valid` is high and `rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle strobe that starts a measurement and clears the flags |
| cfg_mode | input | 2 | 00/11 single, 01 implicit buffered, 10 sample-clocked |
| cfg_gate_low | input | 1 | 1 = measure low pulses of the gate |
| cfg_src_fall | input | 1 | 1 = count falling source edges |
| gate_in | input | 1 | Asynchronous gate signal |
| src_in | input | 1 | Asynchronous periodic source signal |
| smp_in | input | 1 | Asynchronous sample clock (rising edge used) |
| rd_ready | input | 1 | Reader accepts the current entry |
| rd_valid | output | 1 | FIFO holds at least one entry |
| rd_data | output | 32 | Oldest stored width count |
| overrun | output | 1 | Sticky: sample edge with no new pulse |
| fifo_ovf | output | 1 | Sticky: write dropped on a full FIFO |
| sat_flag | output | 1 | Sticky: width counter saturated |

## Verification
The checker checks these properties on every cycle:
- single mode stops after its one result, and the disarmed state holds until `arm`;
- a sample edge with no fresh width raises `overrun`;
- a write on a full FIFO raises `fifo_ovf`, and the sticky flags hold;
- a saturated count stays put until the next leading edge;
- the count does not move outside a measurement;
- held read data stays stable.

Only the bench scenarios can show the measured values themselves: that polarity and edge selection give the right counts, that a pulse cut off by arming is skipped, that the sample-clocked mode reports the latest of several widths exactly once, and that the FIFO keeps its order across an overflow. A behavioural model in the bench shadows every cycle for this.

// File: rtl/pwmeas_pkg.sv
package pwmeas_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_IMPLICIT = 2'b01,
    MODE_SAMPLED  = 2'b10,
    MODE_SINGLE_B = 2'b11
  } meas_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_MEAS = 2'b10
  } meas_st_e;

  function automatic logic is_single(input logic [1:0] mode);
    return (mode == MODE_SINGLE) || (mode == MODE_SINGLE_B);
  endfunction

  function automatic logic is_sampled(input logic [1:0] mode);
    return mode == MODE_SAMPLED;
  endfunction

  function automatic logic leading(input logic now_act, input logic was_act);
    return now_act & ~was_act;
  endfunction

  function automatic logic trailing(input logic now_act, input logic was_act);
    return ~now_act & was_act;
  endfunction

endpackage

// File: rtl/pwmeas_sync.sv
module pwmeas_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic lvl,
  output logic lvl_q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/pwmeas_core.sv
module pwmeas_core
  import pwmeas_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [1:0]       mode,
  input  logic             lead_evt,
  input  logic             trail_evt,
  input  logic             src_evt,
  input  logic             smp_evt,
  output logic             push,
  output logic [CNT_W-1:0] push_data,
  output meas_st_e         st,
  output logic [CNT_W-1:0] cnt,
  output logic             have_new,
  output logic             overrun,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] last_w;
  logic             trail_done;
  logic             smp_take;
  logic             single_m;
  logic             sampled_m;

  function automatic logic [CNT_W-1:0] first_count(input logic edge_now);
    return edge_now ? CNT_W'(1) : '0;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_W'(1);
  endfunction

  assign single_m   = is_single(mode);
  assign sampled_m  = is_sampled(mode);
  assign trail_done = (st == ST_MEAS) && trail_evt;
  assign smp_take   = sampled_m && (st != ST_IDLE) && smp_evt;

  always_comb begin
    push      = 1'b0;
    push_data = trail_done ? cnt : last_w;
    if (!arm) begin
      if (sampled_m) push = smp_take && (trail_done || have_new);
      else           push = trail_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      last_w   <= '0;
      have_new <= 1'b0;
      overrun  <= 1'b0;
      sat      <= 1'b0;
    end else if (arm) begin
      st       <= ST_WAIT;
      cnt      <= '0;
      have_new <= 1'b0;
      overrun  <= 1'b0;
      sat      <= 1'b0;
    end else begin
      unique case (st)
        ST_WAIT: begin
          if (lead_evt) begin
            st  <= ST_MEAS;
            cnt <= first_count(src_evt);
          end
        end
        ST_MEAS: begin
          if (trail_evt) begin
            st <= single_m ? ST_IDLE : ST_WAIT;
            if (sampled_m) begin
              last_w   <= cnt;
              have_new <= 1'b1;
            end
          end else if (src_evt) begin
            if (cnt == CNT_MAX) sat <= 1'b1;
            cnt <= bump(cnt);
          end
        end
        default: ;
      endcase
      if (smp_take) begin
        if (trail_done || have_new) have_new <= 1'b0;
        else                        overrun  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwmeas_fifo.sv
module pwmeas_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_ovf,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = PTR_W + 1;
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_p, rd_p;
  logic [LVL_W-1:0] level;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (level == LVL_FULL);
  assign rd_valid = (level != '0);
  assign rd_data  = mem[rd_p];
  assign do_pop   = rd_valid && pop_ready;
  assign do_push  = push && !full;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p  <= '0;
      rd_p  <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wr_p <= adv(wr_p);
      if (do_pop)  rd_p <= adv(rd_p);
      case ({do_push, do_pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: ;
      endcase
      if (clr_ovf)          ovf <= 1'b0;
      else if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter
  import pwmeas_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DATA_W      = 32,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_gate_low,
  input  logic              cfg_src_fall,
  input  logic              gate_in,
  input  logic              src_in,
  input  logic              smp_in,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              overrun,
  output logic              fifo_ovf,
  output logic              sat_flag
);
  localparam int N_IN = 3;
  localparam int I_GATE = 0;
  localparam int I_SRC  = 1;
  localparam int I_SMP  = 2;

  logic [N_IN-1:0] raw_in, s_lvl, s_prev;

  assign raw_in = {smp_in, src_in, gate_in};

  generate
    for (genvar k = 0; k < N_IN; k++) begin : g_sync
      pwmeas_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in[k]),
        .lvl   (s_lvl[k]),
        .lvl_q (s_prev[k])
      );
    end
  endgenerate

  logic gate_act, gate_act_q;
  logic lead_evt, trail_evt, src_evt, smp_evt;

  assign gate_act   = s_lvl[I_GATE]  ^ cfg_gate_low;
  assign gate_act_q = s_prev[I_GATE] ^ cfg_gate_low;
  assign lead_evt   = leading(gate_act, gate_act_q);
  assign trail_evt  = trailing(gate_act, gate_act_q);
  assign src_evt    = cfg_src_fall ? trailing(s_lvl[I_SRC], s_prev[I_SRC])
                                   : leading(s_lvl[I_SRC], s_prev[I_SRC]);
  assign smp_evt    = leading(s_lvl[I_SMP], s_prev[I_SMP]);

  logic             push_req;
  logic [CNT_W-1:0] push_val;
  meas_st_e         core_st;
  logic [CNT_W-1:0] width_cnt;
  logic             have_new;
  logic             fifo_full;
  logic [CNT_W-1:0] fifo_out;

  pwmeas_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .mode      (cfg_mode),
    .lead_evt  (lead_evt),
    .trail_evt (trail_evt),
    .src_evt   (src_evt),
    .smp_evt   (smp_evt),
    .push      (push_req),
    .push_data (push_val),
    .st        (core_st),
    .cnt       (width_cnt),
    .have_new  (have_new),
    .overrun   (overrun),
    .sat       (sat_flag)
  );

  pwmeas_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_ovf   (arm),
    .push      (push_req),
    .push_data (push_val),
    .pop_ready (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (fifo_out),
    .full      (fifo_full),
    .ovf       (fifo_ovf)
  );

  generate
    if (DATA_W > CNT_W) begin : g_pad
      assign rd_data = {{(DATA_W - CNT_W){1'b0}}, fifo_out};
    end else begin : g_nopad
      assign rd_data = fifo_out[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pulse_width_meter_chk.sv
module pulse_width_meter_chk
  import pwmeas_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic [1:0]        mode,
  input meas_st_e          st,
  input logic [CNT_W-1:0]  cnt,
  input logic              lead_evt,
  input logic              trail_evt,
  input logic              smp_evt,
  input logic              have_new,
  input logic              push_req,
  input logic              fifo_full,
  input logic              fifo_ovf,
  input logic              overrun,
  input logic              sat_flag,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_single_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_single(mode) && st == ST_MEAS && trail_evt && !arm) |=> (st == ST_IDLE));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !arm) |=> (st == ST_IDLE));

  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sampled(mode) && st != ST_IDLE && smp_evt && !have_new
     && !(st == ST_MEAS && trail_evt) && !arm) |=> overrun);

  assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_full && !arm) |=> fifo_ovf);

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && (fifo_ovf || overrun || sat_flag)) |=>
      ((fifo_ovf || !$past(fifo_ovf)) && (overrun || !$past(overrun))
       && (sat_flag || !$past(sat_flag))));

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !arm && !lead_evt) |=> (cnt == CNT_MAX));

  assert_no_count_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_MEAS && !lead_evt && !arm) |=> $stable(cnt));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !push_req) |=> (rd_valid && $stable(rd_data)));
endmodule

bind pulse_width_meter pulse_width_meter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .mode      (cfg_mode),
  .st        (core_st),
  .cnt       (width_cnt),
  .lead_evt  (lead_evt),
  .trail_evt (trail_evt),
  .smp_evt   (smp_evt),
  .have_new  (have_new),
  .push_req  (push_req),
  .fifo_full (fifo_full),
  .fifo_ovf  (fifo_ovf),
  .overrun   (overrun),
  .sat_flag  (sat_flag),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data)
);

// File: tb/sim_pulse_width_meter.sv
`timescale 1ns/1ps
module sim_pulse_width_meter;
  localparam int CW    = 8;
  localparam int DEPTH = 4;
  localparam int MAXC  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic [1:0] cfg_mode = 2'b01;
  logic cfg_gate_low = 1'b0;
  logic cfg_src_fall = 1'b0;
  logic gate_in = 1'b0, src_in = 1'b0, smp_in = 1'b0;
  logic rd_ready = 1'b0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic overrun, fifo_ovf, sat_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pulse_width_meter #(.CNT_W(CW), .DATA_W(32), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_mode(cfg_mode),
    .cfg_gate_low(cfg_gate_low), .cfg_src_fall(cfg_src_fall),
    .gate_in(gate_in), .src_in(src_in), .smp_in(smp_in),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .overrun(overrun), .fifo_ovf(fifo_ovf), .sat_flag(sat_flag)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: delayed copies of the inputs, a phase number, a queue
  int g1, g2, gq, s1, s2, sq, m1, m2, mq;
  int phase;      // 0 disarmed, 1 waiting, 2 measuring
  int width, last_done, fresh;
  int m_over, m_ovf, m_sat;
  int q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      g1 = 0; g2 = 0; gq = 0; s1 = 0; s2 = 0; sq = 0; m1 = 0; m2 = 0; mq = 0;
      phase = 0; width = 0; last_done = 0; fresh = 0;
      m_over = 0; m_ovf = 0; m_sat = 0;
      q.delete();
    end else begin
      int act, actq, up, down, sedge, tick, do_wr, wval, pre, single, sampled, ended;
      act  = g2 ^ int'(cfg_gate_low);
      actq = gq ^ int'(cfg_gate_low);
      up   = act && !actq;
      down = !act && actq;
      sedge = cfg_src_fall ? (!s2 && sq) : (s2 && !sq);
      tick = m2 && !mq;
      single  = (cfg_mode == 2'b00 || cfg_mode == 2'b11);
      sampled = (cfg_mode == 2'b10);
      do_wr = 0; wval = 0;
      pre = q.size();
      if (arm) begin
        phase = 1; width = 0; fresh = 0; m_over = 0; m_sat = 0; m_ovf = 0;
      end else begin
        ended = (phase == 2) && down;
        if (sampled && phase != 0 && tick) begin
          if (ended) begin do_wr = 1; wval = width; end
          else if (fresh) begin do_wr = 1; wval = last_done; fresh = 0; end
          else m_over = 1;
        end else if (ended && !sampled) begin
          do_wr = 1; wval = width;
        end
        if (phase == 1 && up) begin
          phase = 2; width = sedge ? 1 : 0;
        end else if (ended) begin
          if (sampled && !(tick)) begin last_done = width; fresh = 1; end
          phase = single ? 0 : 1;
        end else if (phase == 2 && sedge) begin
          if (width == MAXC) m_sat = 1; else width = width + 1;
        end
      end
      if (rd_ready && pre > 0) void'(q.pop_front());
      if (do_wr) begin
        if (pre >= DEPTH) m_ovf = 1; else q.push_back(wval);
      end
      gq = g2; g2 = g1; g1 = int'(gate_in);
      sq = s2; s2 = s1; s1 = int'(src_in);
      mq = m2; m2 = m1; m1 = int'(smp_in);
    end
  end

  // cycle-by-cycle comparison against the reference (R11 ordering, flags)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 model valid", rd_valid, q.size() > 0);
      if (q.size() > 0) chk("R11 model data", rd_data, q[0]);
      chk("R8 model overrun", overrun, m_over);
      chk("R10 model fifo_ovf", fifo_ovf, m_ovf);
      chk("R9 model sat", sat_flag, m_sat);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1; cyc(1); arm = 1'b0; cyc(1);
  endtask

  task automatic pulse(input int n);
    gate_in = ~cfg_gate_low; cyc(2);
    for (int i = 0; i < n; i++) begin
      src_in = 1'b1; cyc(2); src_in = 1'b0; cyc(2);
    end
    cyc(1); gate_in = cfg_gate_low; cyc(5);
  endtask

  // k falling edges and k-1 rising edges inside the pulse
  task automatic pulse_fall(input int k);
    src_in = 1'b1; cyc(3);
    gate_in = ~cfg_gate_low; cyc(2);
    src_in = 1'b0; cyc(2);
    for (int i = 1; i < k; i++) begin
      src_in = 1'b1; cyc(2); src_in = 1'b0; cyc(2);
    end
    gate_in = cfg_gate_low; cyc(2);
    src_in = 1'b1; cyc(3); src_in = 1'b0; cyc(3);
  endtask

  task automatic tick();
    smp_in = 1'b1; cyc(3); smp_in = 1'b0; cyc(3);
  endtask

  task automatic pop_expect(input string tag, input int exp);
    int w = 0;
    while (!rd_valid && w < 60) begin cyc(1); w++; end
    chk(tag, rd_data, exp);
    rd_ready = 1'b1; cyc(1); rd_ready = 1'b0;
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    chk("R1 reset valid", rd_valid, 0);
    chk("R1 reset flags", {overrun, fifo_ovf, sat_flag}, 0);
    pulse(3); cyc(4);
    chk("R1 disarmed stores nothing", rd_valid, 0);

    // implicit mode, high pulses, rising edges
    cfg_mode = 2'b01; do_arm();
    pulse(3); pulse(5); pulse(1);
    pop_expect("R6 first", 3); pop_expect("R6 second", 5); pop_expect("R3 one edge", 1);

    // low pulses
    gate_in = 1'b1; cfg_gate_low = 1'b1; cyc(6); do_arm();
    pulse(4); pop_expect("R2 low pulse", 4);
    gate_in = 1'b0; cfg_gate_low = 1'b0; cyc(6);

    // edge selection
    do_arm(); pulse_fall(3); pop_expect("R3 rising selected", 2);
    cfg_src_fall = 1'b1; cyc(2); do_arm();
    pulse_fall(3); pop_expect("R3 falling selected", 3);
    cfg_src_fall = 1'b0; cyc(2);

    // arm in the middle of a pulse
    gate_in = 1'b1; cyc(4); do_arm();
    src_in = 1'b1; cyc(2); src_in = 1'b0; cyc(2); src_in = 1'b1; cyc(2); src_in = 1'b0; cyc(2);
    gate_in = 1'b0; cyc(6);
    chk("R4 partial pulse skipped", rd_valid, 0);
    pulse(6); pop_expect("R4 next full pulse", 6);

    // single mode
    cfg_mode = 2'b00; cyc(1); do_arm();
    pulse(2); pulse(7); cyc(4);
    pop_expect("R5 single result", 2); cyc(2);
    chk("R5 later pulses ignored", rd_valid, 0);
    cfg_mode = 2'b11; cyc(1); do_arm();
    pulse(4); pulse(1); pop_expect("R5 alt code", 4); cyc(2);
    chk("R5 alt ignored", rd_valid, 0);

    // sample-clocked mode
    cfg_mode = 2'b10; cyc(1); do_arm();
    pulse(3); tick(); pop_expect("R7 sampled width", 3);
    chk("R8 no overrun", overrun, 0);
    pulse(2); pulse(5); tick(); pop_expect("R7 latest width", 5); cyc(2);
    chk("R7 written once", rd_valid, 0);
    tick(); cyc(2);
    chk("R8 overrun set", overrun, 1);
    chk("R8 nothing written", rd_valid, 0);
    do_arm();
    chk("R10 arm clears overrun", overrun, 0);

    // saturation
    cfg_mode = 2'b01; cyc(1); do_arm();
    pulse(MAXC + 40); pop_expect("R9 saturated count", MAXC);
    chk("R9 sat flag", sat_flag, 1);
    do_arm();
    chk("R10 arm clears sat", sat_flag, 0);

    // FIFO overflow
    for (int i = 1; i <= DEPTH + 1; i++) pulse(i);
    cyc(2);
    chk("R10 overflow flag", fifo_ovf, 1);
    for (int i = 1; i <= DEPTH; i++) pop_expect("R10 kept order", i);
    cyc(2);
    chk("R10 dropped entry", rd_valid, 0);
    do_arm();
    chk("R10 arm clears ovf", fifo_ovf, 0);

    cyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule